// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs an external successive-approximation converter through a sequence of conversions. A write strobe, carrying four configuration fields, starts a sequence. The fields are the sequence length (four or eight conversions), the repeat mode (once or continuous), the channel mode (one channel or a stepped group) and a 4-bit select code. For each conversion the block presents a mux code to the converter and, one clock later, a one-cycle start pulse. It then waits for the converter's done strobe, which comes with a 10-bit result, and stores that result in its slot of an eight-entry result bank. A flag rises once the last slot of a sequence is written.

The converter link is a request/acknowledge pulse pair, not a valid/ready stream. The block issues at most one start before it receives a done. It never stalls the converter. The converter must not raise done without a start that is still outstanding, and there is no back-pressure on either side. Results are read at any time through a combinational slot-select port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A cycle with `ctl_wr` high latches the four configuration fields and starts a sequence. `conv_start` is low in the first cycle after the write and high in the second cycle.
- R2: With `ctl_len8` = 0 a sequence has four conversions. With `ctl_len8` = 1 it has eight.
- R3: With `ctl_scan` = 0 no start is issued after the last result of the sequence. With `ctl_scan` = 1 the next sequence begins at once, starting again at conversion 0 and slot 0.
- R4: With `ctl_multi` = 0 every conversion uses `conv_mux` = `ctl_sel`. Conversion i stores into slot i, so results land in slots 0, 1, 2, … in order.
- R5: With `ctl_multi` = 1 and `ctl_len8` = 0, conversion i (i = 0..3) uses `conv_mux` = {`ctl_sel[3:2]`, i[1:0]} and stores into slot i.
- R6: With `ctl_multi` = 1 and `ctl_len8` = 1, conversion i (i = 0..7) uses `conv_mux` = {`ctl_sel[3]`, i[2:0]} and stores into slot i.
- R7: The converter decodes mux codes as follows: 0 to 7 are input pins, 12 is the high reference, 13 is the low reference, 14 is their midpoint, and 8 to 11 and 15 are reserved or test. The block passes every code to the converter unaltered, so a reference code selected in single-channel mode reaches `conv_mux`.
- R8: `conv_start` is one cycle wide. It rises two clock edges after the edge that samples `conv_done` high, and `conv_mux` holds the same value in the cycle before the start and in the start cycle.
- R9: `seq_done` rises on the edge that stores the last result of a sequence. In scan mode it stays high while later sequences run. A write clears it by the next cycle.
- R10: A write during a running sequence abandons it and restarts from conversion 0, slot 0, using the new configuration.
- R11: A `conv_done` that arrives while no conversion is outstanding is ignored: no slot changes and no start is issued.
- R12: After reset, `seq_done` and `conv_start` are low, `conv_mux` is 0 and every slot reads 0. `rd_data` shows slot `rd_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Configuration write strobe; starts a sequence |
| ctl_len8 | input | 1 | 0: four conversions, 1: eight |
| ctl_scan | input | 1 | 0: one sequence, 1: repeat continuously |
| ctl_multi | input | 1 | 0: single channel, 1: stepped channel group |
| ctl_sel | input | 4 | Channel select code |
| conv_mux | output | 4 | Mux code presented to the converter |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| rd_sel | input | 3 | Result slot to read |
| rd_data | output | 10 | Contents of slot `rd_sel` |
| seq_done | output | 1 | Sequence-complete flag |

## Verification
The assertions watch every cycle for the pulse shape of `conv_start` and for a steady `conv_mux` under it. They also check that a write clears `seq_done` and keeps the start low in the following cycle, and that `seq_done` only rises right after a done strobe. The channel walk in each mode, the slot each result lands in, the sequence lengths, scan restarts, aborts and ignored stray strobes need whole sequences to show. The bench's scenarios check these against its own converter model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             len8;
    logic             scan;
    logic             multi;
    logic [SEL_W-1:0] sel;
  } seq_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_seq_chan_map.sv
module adc_seq_chan_map
  import adc_seq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  seq_cfg_t         cfg,
  input  logic [IDX_W-1:0] idx,
  output logic [SEL_W-1:0] code
);
  localparam logic [SEL_W-1:0] MASK_LONG  = SEL_W'((1 << IDX_W) - 1);
  localparam logic [SEL_W-1:0] MASK_SHORT = SEL_W'((1 << (IDX_W - 1)) - 1);

  logic [SEL_W-1:0] mask;
  logic [SEL_W-1:0] idx_ext;

  always_comb begin
    mask    = cfg.len8 ? MASK_LONG : MASK_SHORT;
    idx_ext = SEL_W'(idx);
    if (cfg.multi) code = (cfg.sel & ~mask) | (idx_ext & mask);
    else           code = cfg.sel;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  seq_cfg_t         cfg_in,
  input  logic             done,
  output seq_cfg_t         cfg,
  output logic [IDX_W-1:0] idx,
  output logic             start,
  output logic             store_en,
  output logic             flag
);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(SLOTS - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SLOTS / 2 - 1);

  seq_state_t       state_q;
  seq_cfg_t         cfg_q;
  logic [IDX_W-1:0] idx_q;
  logic             flag_q;
  logic [IDX_W-1:0] last_idx;
  logic             at_last;

  assign last_idx = cfg_q.len8 ? LAST_LONG : LAST_SHORT;
  assign at_last  = (idx_q == last_idx);
  assign store_en = (state_q == ST_WAIT) && done && !wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      idx_q   <= '0;
      flag_q  <= 1'b0;
    end else if (wr) begin
      state_q <= ST_SETUP;
      cfg_q   <= cfg_in;
      idx_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SETUP: state_q <= ST_PULSE;
        ST_PULSE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (done) begin
            if (at_last) begin
              flag_q <= 1'b1;
              idx_q  <= '0;
              state_q <= cfg_q.scan ? ST_SETUP : ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_SETUP;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg   = cfg_q;
  assign idx   = idx_q;
  assign start = (state_q == ST_PULSE);
  assign flag  = flag_q;
endmodule

// File: rtl/adc_seq_result_bank.sv
module adc_seq_result_bank #(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 10,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                           slot_q[g] <= '0;
      else if (we && (widx == IDX_W'(g)))   slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[ridx];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_len8,
  input  logic              ctl_scan,
  input  logic              ctl_multi,
  input  logic [SEL_W-1:0]  ctl_sel,
  output logic [SEL_W-1:0]  conv_mux,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              seq_done
);
  seq_cfg_t         cfg_in;
  seq_cfg_t         cfg;
  logic [IDX_W-1:0] idx;
  logic             store_en;

  assign cfg_in = '{len8: ctl_len8, scan: ctl_scan, multi: ctl_multi, sel: ctl_sel};

  adc_seq_fsm #(.SLOTS(SLOTS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .cfg_in   (cfg_in),
    .done     (conv_done),
    .cfg      (cfg),
    .idx      (idx),
    .start    (conv_start),
    .store_en (store_en),
    .flag     (seq_done)
  );

  adc_seq_chan_map #(.IDX_W(IDX_W)) u_map (
    .cfg  (cfg),
    .idx  (idx),
    .code (conv_mux)
  );

  adc_seq_result_bank #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_en),
    .widx  (idx),
    .wdata (conv_data),
    .ridx  (rd_sel),
    .rdata (rd_data)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             conv_start,
  input logic             conv_done,
  input logic [SEL_W-1:0] conv_mux,
  input logic             seq_done
);
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_mux_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $stable(conv_mux));

  assert_wr_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !seq_done);

  assert_flag_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(conv_done));

  assert_wr_setup_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !conv_start);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .conv_mux   (conv_mux),
  .seq_done   (seq_done)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int LAT = 3;
  // vector fields: [6] len8, [5] scan, [4] multi, [3:0] sel
  localparam logic [6:0] VEC [8] = '{7'b0000101, 7'b1000010, 7'b0010110, 7'b0010011,
                                     7'b1010101, 7'b1011010, 7'b0001100, 7'b1001110};

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_len8 = 0, ctl_scan = 0, ctl_multi = 0;
  logic [3:0] ctl_sel = 0, conv_mux;
  logic conv_start, conv_done = 0, seq_done;
  logic [9:0] conv_data = 0, rd_data;
  logic [2:0] rd_sel = 0;

  adc_seq_ctrl dut (.clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_len8(ctl_len8),
    .ctl_scan(ctl_scan), .ctl_multi(ctl_multi), .ctl_sel(ctl_sel), .conv_mux(conv_mux),
    .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .seq_done(seq_done));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int nstart = 0, nconv = 0, cd = 0;
  logic [3:0] cur_code = 0;
  logic [3:0] log_code [512];
  logic inject = 0;

  // converter model
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (inject) begin
      conv_done <= 1'b1;
      conv_data <= 10'h3AA;
    end else if (ctl_wr) begin
      cd <= 0;
    end else if (conv_start) begin
      cd <= LAT;
      cur_code <= conv_mux;
      log_code[nstart % 512] <= conv_mux;
      nstart <= nstart + 1;
    end else if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        conv_done <= 1'b1;
        conv_data <= {cur_code, 6'(nconv)};
        nconv <= nconv + 1;
      end
    end
  end

  // timing monitor for R8
  int ecount = 0, de = 0, gap_seen = 0, gap_bad = 0;
  bit pend = 0, prev_start = 0;
  logic [3:0] prev_mux = 0;
  always @(posedge clk) begin
    ecount++;
    if (ctl_wr) pend = 0;
    if (conv_start && rst_n) begin
      if (prev_start || prev_mux != conv_mux) gap_bad++;
      if (pend) begin
        gap_seen++;
        if (ecount - de != 2) gap_bad++;
        pend = 0;
      end
    end
    if (conv_done) begin pend = 1; de = ecount; end
    prev_start = conv_start;
    prev_mux = conv_mux;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input logic [6:0] v, input int i);
    if (!v[4]) return v[3:0];
    if (v[6]) return {v[3], 3'(i)};
    return {v[3:2], 2'(i)};
  endfunction

  int base_s, base_c;
  task automatic start_seq(input logic [6:0] v, input bit timing);
    @(negedge clk);
    {ctl_len8, ctl_scan, ctl_multi, ctl_sel} = v;
    ctl_wr = 1;
    base_s = nstart;
    base_c = nconv;
    @(negedge clk);
    ctl_wr = 0;
    if (timing) begin
      chk("R1", "start in cycle 1 after write", conv_start, 0);
      @(negedge clk);
      chk("R1", "start in cycle 2 after write", conv_start, 1);
      chk("R1", "first mux code", conv_mux, exp_code(v, 0));
    end
  endtask

  task automatic wait_flag();
    for (int k = 0; k < 600 && !seq_done; k++) @(negedge clk);
  endtask

  task automatic check_run(input logic [6:0] v);
    int n;
    string tag;
    n = v[6] ? 8 : 4;
    tag = !v[4] ? (v[3] ? "R7" : "R4") : (v[6] ? "R6" : "R5");
    chk("R2", "conversions in sequence", nstart - base_s, n);
    for (int i = 0; i < n; i++) begin
      chk(tag, $sformatf("mux code of conversion %0d", i), log_code[(base_s + i) % 512], exp_code(v, i));
      rd_sel = 3'(i);
      #1;
      chk(tag, $sformatf("slot %0d", i), rd_data, {exp_code(v, i), 6'(base_c + i)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [9:0] saved [8];
  int s0, c0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "seq_done after reset", seq_done, 0);
    chk("R12", "conv_start after reset", conv_start, 0);
    chk("R12", "conv_mux after reset", conv_mux, 0);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i); #1;
      chk("R12", $sformatf("slot %0d after reset", i), rd_data, 0);
    end

    // vector table
    foreach (VEC[j]) begin
      start_seq(VEC[j], 1);
      wait_flag();
      chk("R9", "flag after last result", seq_done, 1);
      repeat (12) @(negedge clk);
      chk("R3", "no start after single sequence", conv_start, 0);
      check_run(VEC[j]);
    end

    // R11: stray done while idle
    for (int i = 0; i < 8; i++) begin rd_sel = 3'(i); #1; saved[i] = rd_data; end
    s0 = nstart;
    @(negedge clk); inject = 1;
    @(negedge clk); inject = 0;
    repeat (6) @(negedge clk);
    chk("R11", "starts after stray done", nstart - s0, 0);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i); #1;
      chk("R11", $sformatf("slot %0d after stray done", i), rd_data, saved[i]);
    end

    // R10: abort mid-sequence
    start_seq(7'b1010000, 0);
    for (int k = 0; k < 200 && nstart - base_s < 3; k++) @(negedge clk);
    start_seq(7'b0010100, 0);
    chk("R9", "flag cleared by write", seq_done, 0);
    wait_flag();
    repeat (12) @(negedge clk);
    chk("R10", "restart after abort", conv_start, 0);
    check_run(7'b0010100);

    // R3/R9: scan mode
    start_seq(7'b0100011, 0);
    wait_flag();
    c0 = base_c;
    for (int k = 0; k < 200 && nconv < c0 + 6; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9", "flag held during scan", seq_done, 1);
    chk("R3", "scan keeps converting", (nstart - base_s) > 5, 1);
    rd_sel = 0; #1;
    chk("R3", "scan pass two slot 0", rd_data, {4'd3, 6'(c0 + 4)});
    rd_sel = 1; #1;
    chk("R3", "scan pass two slot 1", rd_data, {4'd3, 6'(c0 + 5)});
    start_seq(7'b0000001, 0);
    chk("R9", "write clears flag in scan", seq_done, 0);
    wait_flag();
    repeat (12) @(negedge clk);
    check_run(7'b0000001);

    chk("R8", "start timing violations", gap_bad, 0);
    chk("R8", "done-to-start gaps measured", gap_seen > 20, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule